// File: doc/BRIEF.md
# Life Cycle Transition Sequencer

This block keeps a device's life cycle state and the number of transition attempts made so far. After reset it loads the stored state and attempt count once, through a single-cycle initialisation strobe. It checks both values for corruption and then reports them. Software or a test port can then fire a single-cycle start. The start carries a target state and a 128-bit token. The block decides whether the move is allowed and whether the token authorises it. It then runs one request/acknowledge write towards a non-volatile store, carrying the new count and the resulting state, and records the outcome in sticky status flags.

Each attempt consumes one count step and leaves the block in a temporary post-transition state, whether the attempt succeeded or failed. Only a reset followed by a fresh load allows another attempt. The state encoding is ordered, so a legal move is always towards a higher code. An escalation input, a failed write, or a corrupt stored value drives the block into an escalated state that behaves like scrap. The last two cases also raise a fatal alert.

Top module: `lifecycle_seq`

## Requirements
- R1: While reset is held, and until initialisation, the outputs are: state_o = 23 (invalid), count_o = 0, all status flags 0, alert_o = 0, prog_req_o = 0.
- R2: The first init_valid_i pulse after reset loads init_state_i and init_count_i. ready_o, state_o and count_o show the loaded values one cycle later. Later pulses are ignored.
- R3: A loaded count above MAX_ATT (16) reads back as all ones (31). A loaded state above 20 is also corrupt. Either fault sets state_err_o and alert_o and shows state_o = 22 (escalated).
- R4: A move to a strictly higher code up to 20 (scrap) with a correct token succeeds. After the acknowledge: success_o = 1, count_o = previous + 1, state_o = 21 (post-transition).
- R5: A target that is equal, lower, or above 20 sets trans_err_o. It still consumes a count step and ends in state 21.
- R6: A move from 18 (production-end) to 19 (return state) is illegal even though its code is higher. It sets trans_err_o.
- R7: A move out of an even state 2..14 (locked test states) needs token UNLOCK_TOKEN. A move into 19 needs RMA_TOKEN; this check takes priority over the first. A mismatch on a legal move sets token_err_o.
- R8: Every other move needs an all-zero token, otherwise token_err_o is set.
- R9: prog_req_o rises one cycle after an accepted start and holds until prog_ack_i. While it is high: prog_count_o = count + 1, and prog_state_o = the target if the move is legal and authorised, otherwise the current state. prog_req_o drops one cycle after the acknowledge.
- R10: An acknowledge with prog_err_i set sets otp_err_o and alert_o and moves state_o to 22. The count still advances.
- R11: When the count equals 16, cnt_err_o is 1 and state_o reads 20. Starts are then refused.
- R12: A start is ignored before ready, while a request is pending, from states 20..23, and after escalation.
- R13: esc_i moves state_o to 22 one cycle later. A pending request is withdrawn without advancing the count, unless prog_ack_i arrives in the same cycle. In that case the count and flags of that acknowledge apply, but the state still reads 22.
- R14: The status flags and alert_o hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| init_valid_i | input | 1 | Load strobe for stored state and count |
| init_state_i | input | 5 | Stored state code |
| init_count_i | input | CNT_W | Stored attempt count |
| start_i | input | 1 | Transition start pulse |
| target_i | input | 5 | Requested state code |
| token_i | input | TOKEN_W | Authorisation token |
| prog_ack_i | input | 1 | Write acknowledge from the store |
| prog_err_i | input | 1 | Write failed, valid with the acknowledge |
| esc_i | input | 1 | Escalation request |
| state_o | output | 5 | Reported state code |
| count_o | output | CNT_W | Reported attempt count |
| ready_o | output | 1 | Initialisation complete |
| success_o | output | 1 | Last attempt succeeded |
| cnt_err_o | output | 1 | Attempt budget exhausted |
| trans_err_o | output | 1 | Illegal move requested |
| token_err_o | output | 1 | Token mismatch |
| otp_err_o | output | 1 | Write to the store failed |
| state_err_o | output | 1 | Corrupt stored state or count |
| alert_o | output | 1 | Fatal alert |
| prog_req_o | output | 1 | Write request to the store |
| prog_state_o | output | 5 | State code to write |
| prog_count_o | output | CNT_W | Count to write |

## Verification
Escalation and the write acknowledge can land on the same clock edge. Escalation can also arrive while a request is still waiting for its acknowledge. The bench provokes both: in one run esc_i and prog_ack_i are driven high on the same cycle, and in another esc_i rises during a pending request, followed by a late acknowledge. The behavioural model decides every cycle. In the collision case the count must advance and success_o must rise, while state_o reads 22. In the withdrawal case prog_req_o must drop, and the late acknowledge must leave the count untouched.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  localparam int unsigned ST_W = 5;
  typedef logic [ST_W-1:0] lc_state_t;

  // ordered codes; legality relies on numeric order
  localparam lc_state_t ST_LOCK_LO  = 5'd2;
  localparam lc_state_t ST_LOCK_HI  = 5'd14;
  localparam lc_state_t ST_PROD_END = 5'd18;
  localparam lc_state_t ST_RMA      = 5'd19;
  localparam lc_state_t ST_SCRAP    = 5'd20;
  localparam lc_state_t ST_POST     = 5'd21;
  localparam lc_state_t ST_ESC      = 5'd22;
  localparam lc_state_t ST_BAD      = 5'd23;

  // locked test states are the even codes 2..14
  function automatic logic is_locked(lc_state_t s);
    return (s >= ST_LOCK_LO) && (s <= ST_LOCK_HI) && !s[0];
  endfunction
endpackage

// File: rtl/lcs_init_check.sv
module lcs_init_check import lcs_pkg::*; #(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned MAX_ATT = 16
) (
  input  lc_state_t        raw_state_i,
  input  logic [CNT_W-1:0] raw_cnt_i,
  output logic             state_ok_o,
  output logic             cnt_ok_o,
  output logic             cnt_full_o
);
  localparam logic [CNT_W-1:0] CntLimit = CNT_W'(MAX_ATT);

  assign state_ok_o = (raw_state_i <= ST_SCRAP);
  assign cnt_ok_o   = (raw_cnt_i <= CntLimit);
  assign cnt_full_o = (raw_cnt_i == CntLimit);
endmodule

// File: rtl/lcs_rule_check.sv
module lcs_rule_check import lcs_pkg::*; #(
  parameter int unsigned       TOKEN_W      = 128,
  parameter logic [TOKEN_W-1:0] UNLOCK_TOKEN = '0,
  parameter logic [TOKEN_W-1:0] RMA_TOKEN    = '0
) (
  input  lc_state_t          cur_i,
  input  lc_state_t          tgt_i,
  input  logic [TOKEN_W-1:0] token_i,
  output logic               legal_o,
  output logic               tok_ok_o
);
  logic [TOKEN_W-1:0] need;

  always_comb begin
    need = '0;
    if (tgt_i == ST_RMA) begin
      need = RMA_TOKEN;
    end else if (is_locked(cur_i)) begin
      need = UNLOCK_TOKEN;
    end
    tok_ok_o = (token_i == need);
    legal_o  = (tgt_i > cur_i) && (tgt_i <= ST_SCRAP) &&
               !((cur_i == ST_PROD_END) && (tgt_i == ST_RMA));
  end
endmodule

// File: rtl/lcs_prog_if.sv
module lcs_prog_if import lcs_pkg::*; #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             launch_i,
  input  logic             legal_i,
  input  logic             tok_ok_i,
  input  lc_state_t        tgt_i,
  input  lc_state_t        cur_i,
  input  logic [CNT_W-1:0] cnt_next_i,
  input  logic             ack_i,
  input  logic             err_i,
  input  logic             abort_i,
  output logic             req_o,
  output lc_state_t        pstate_o,
  output logic [CNT_W-1:0] pcount_o,
  output logic             v_legal_o,
  output logic             v_tok_o,
  output logic             fin_o,
  output logic             fin_err_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      req_o     <= 1'b0;
      pstate_o  <= ST_BAD;
      pcount_o  <= '0;
      v_legal_o <= 1'b0;
      v_tok_o   <= 1'b0;
    end else if (launch_i) begin
      req_o     <= 1'b1;
      pstate_o  <= (legal_i && tok_ok_i) ? tgt_i : cur_i;
      pcount_o  <= cnt_next_i;
      v_legal_o <= legal_i;
      v_tok_o   <= tok_ok_i;
    end else if (req_o && (ack_i || abort_i)) begin
      req_o <= 1'b0;
    end
  end

  assign fin_o     = req_o & ack_i;
  assign fin_err_o = req_o & ack_i & err_i;
endmodule

// File: rtl/lifecycle_seq.sv
module lifecycle_seq import lcs_pkg::*; #(
  parameter int unsigned        CNT_W        = 5,
  parameter int unsigned        MAX_ATT      = 16,
  parameter int unsigned        TOKEN_W      = 128,
  parameter logic [TOKEN_W-1:0] UNLOCK_TOKEN = 128'h3c5a_9e01_77d2_40bb_c418_6f2e_915d_a06c,
  parameter logic [TOKEN_W-1:0] RMA_TOKEN    = 128'h82f1_0b6d_e93a_5c47_1d08_b2ce_6a95_f314
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               init_valid_i,
  input  logic [ST_W-1:0]    init_state_i,
  input  logic [CNT_W-1:0]   init_count_i,
  input  logic               start_i,
  input  logic [ST_W-1:0]    target_i,
  input  logic [TOKEN_W-1:0] token_i,
  input  logic               prog_ack_i,
  input  logic               prog_err_i,
  input  logic               esc_i,
  output logic [ST_W-1:0]    state_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               ready_o,
  output logic               success_o,
  output logic               cnt_err_o,
  output logic               trans_err_o,
  output logic               token_err_o,
  output logic               otp_err_o,
  output logic               state_err_o,
  output logic               alert_o,
  output logic               prog_req_o,
  output logic [ST_W-1:0]    prog_state_o,
  output logic [CNT_W-1:0]   prog_count_o
);
  localparam logic [CNT_W-1:0] CntLimit = CNT_W'(MAX_ATT);
  localparam logic [CNT_W-1:0] CntBad   = '1;

  lc_state_t        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic ready_q, esc_q, succ_q, cfull_q, terr_q, tkerr_q, oerr_q, serr_q, alert_q;

  logic st_ok, cnt_ok, cnt_full;
  logic legal, tok_ok, launch;
  logic req, v_legal, v_tok, fin, fin_err;
  lc_state_t        pstate;
  logic [CNT_W-1:0] pcount;

  lcs_init_check #(.CNT_W(CNT_W), .MAX_ATT(MAX_ATT)) u_init (
    .raw_state_i (init_state_i),
    .raw_cnt_i   (init_count_i),
    .state_ok_o  (st_ok),
    .cnt_ok_o    (cnt_ok),
    .cnt_full_o  (cnt_full)
  );

  lcs_rule_check #(.TOKEN_W(TOKEN_W), .UNLOCK_TOKEN(UNLOCK_TOKEN), .RMA_TOKEN(RMA_TOKEN)) u_rule (
    .cur_i    (st_q),
    .tgt_i    (target_i),
    .token_i  (token_i),
    .legal_o  (legal),
    .tok_ok_o (tok_ok)
  );

  assign launch = start_i & ready_q & ~req & ~esc_q & ~esc_i & (st_q < ST_SCRAP);

  lcs_prog_if #(.CNT_W(CNT_W)) u_prog (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .launch_i   (launch),
    .legal_i    (legal),
    .tok_ok_i   (tok_ok),
    .tgt_i      (target_i),
    .cur_i      (st_q),
    .cnt_next_i (cnt_q + CNT_W'(1)),
    .ack_i      (prog_ack_i),
    .err_i      (prog_err_i),
    .abort_i    (esc_i),
    .req_o      (req),
    .pstate_o   (pstate),
    .pcount_o   (pcount),
    .v_legal_o  (v_legal),
    .v_tok_o    (v_tok),
    .fin_o      (fin),
    .fin_err_o  (fin_err)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q    <= ST_BAD;
      cnt_q   <= '0;
      ready_q <= 1'b0;
      esc_q   <= 1'b0;
      succ_q  <= 1'b0;
      cfull_q <= 1'b0;
      terr_q  <= 1'b0;
      tkerr_q <= 1'b0;
      oerr_q  <= 1'b0;
      serr_q  <= 1'b0;
      alert_q <= 1'b0;
    end else begin
      if (!ready_q && init_valid_i) begin
        ready_q <= 1'b1;
        cnt_q   <= cnt_ok ? init_count_i : CntBad;
        cfull_q <= cnt_ok & cnt_full;
        if (!cnt_ok || !st_ok) begin
          serr_q  <= 1'b1;
          alert_q <= 1'b1;
          st_q    <= ST_ESC;
        end else begin
          st_q <= cnt_full ? ST_SCRAP : init_state_i;
        end
      end
      if (fin) begin
        cnt_q <= pcount;
        if (pcount == CntLimit) cfull_q <= 1'b1;
        if (fin_err) begin
          oerr_q  <= 1'b1;
          alert_q <= 1'b1;
          st_q    <= ST_ESC;
        end else begin
          succ_q  <= v_legal & v_tok;
          terr_q  <= ~v_legal;
          tkerr_q <= v_legal & ~v_tok;
          st_q    <= (pcount == CntLimit) ? ST_SCRAP : ST_POST;
        end
      end
      if (esc_i) esc_q <= 1'b1;
      if (esc_i || esc_q) st_q <= ST_ESC;
    end
  end

  assign state_o      = st_q;
  assign count_o      = cnt_q;
  assign ready_o      = ready_q;
  assign success_o    = succ_q;
  assign cnt_err_o    = cfull_q;
  assign trans_err_o  = terr_q;
  assign token_err_o  = tkerr_q;
  assign otp_err_o    = oerr_q;
  assign state_err_o  = serr_q;
  assign alert_o      = alert_q;
  assign prog_req_o   = req;
  assign prog_state_o = pstate;
  assign prog_count_o = pcount;
endmodule

// File: rtl/lcs_checker.sv
module lcs_checker import lcs_pkg::*; #(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned MAX_ATT = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             esc_i,
  input logic             prog_ack_i,
  input lc_state_t        state_o,
  input logic [CNT_W-1:0] count_o,
  input logic             ready_o,
  input logic             success_o,
  input logic             trans_err_o,
  input logic             token_err_o,
  input logic             otp_err_o,
  input logic             alert_o,
  input logic             prog_req_o,
  input lc_state_t        prog_state_o,
  input logic [CNT_W-1:0] prog_count_o
);
  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    prog_req_o && !prog_ack_i && !esc_i |=> prog_req_o && $stable(prog_state_o) && $stable(prog_count_o));

  a_r9_req_drop: assert property (@(posedge clk_i) disable iff (rst_i)
    prog_req_o && prog_ack_i |=> !prog_req_o);

  a_r13_escalate: assert property (@(posedge clk_i) disable iff (rst_i)
    esc_i |=> state_o == ST_ESC);

  a_r14_alert_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    alert_o |=> alert_o);

  a_r14_err_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    (trans_err_o || token_err_o || otp_err_o) |=>
      ($past(trans_err_o) -> trans_err_o) && ($past(token_err_o) -> token_err_o) &&
      ($past(otp_err_o) -> otp_err_o));

  a_r6_no_end_to_rma: assert property (@(posedge clk_i) disable iff (rst_i)
    prog_req_o && state_o == ST_PROD_END |-> prog_state_o != ST_RMA);

  a_r11_full_is_scrap: assert property (@(posedge clk_i) disable iff (rst_i)
    ready_o && count_o == CNT_W'(MAX_ATT) && state_o != ST_ESC |-> state_o == ST_SCRAP);

  a_r4_success_clean: assert property (@(posedge clk_i) disable iff (rst_i)
    success_o |-> !trans_err_o && !token_err_o);

  a_r12_no_req_unready: assert property (@(posedge clk_i) disable iff (rst_i)
    !ready_o |-> !prog_req_o);
endmodule

bind lifecycle_seq lcs_checker #(.CNT_W(CNT_W), .MAX_ATT(MAX_ATT)) u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .esc_i        (esc_i),
  .prog_ack_i   (prog_ack_i),
  .state_o      (state_o),
  .count_o      (count_o),
  .ready_o      (ready_o),
  .success_o    (success_o),
  .trans_err_o  (trans_err_o),
  .token_err_o  (token_err_o),
  .otp_err_o    (otp_err_o),
  .alert_o      (alert_o),
  .prog_req_o   (prog_req_o),
  .prog_state_o (prog_state_o),
  .prog_count_o (prog_count_o)
);

// File: tb/sim_lifecycle_seq.sv
module sim_lifecycle_seq;
  localparam int CW = 5;
  localparam int TW = 128;
  localparam logic [TW-1:0] K_UNL = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
  localparam logic [TW-1:0] K_RMA = 128'h9999_aaaa_bbbb_cccc_dddd_eeee_ffff_0001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          init_valid = 0, start = 0, ack = 0, ack_err = 0, esc = 0;
  logic [4:0]    init_state = 0, target = 0;
  logic [CW-1:0] init_count = 0;
  logic [TW-1:0] token = 0;

  logic [4:0]    state_o, prog_state_o;
  logic [CW-1:0] count_o, prog_count_o;
  logic ready_o, success_o, cnt_err_o, trans_err_o, token_err_o;
  logic otp_err_o, state_err_o, alert_o, prog_req_o;

  lifecycle_seq #(.CNT_W(CW), .MAX_ATT(16), .TOKEN_W(TW), .UNLOCK_TOKEN(K_UNL), .RMA_TOKEN(K_RMA)) u0 (
    .clk_i(clk), .rst_i(rst), .init_valid_i(init_valid), .init_state_i(init_state),
    .init_count_i(init_count), .start_i(start), .target_i(target), .token_i(token),
    .prog_ack_i(ack), .prog_err_i(ack_err), .esc_i(esc), .state_o(state_o),
    .count_o(count_o), .ready_o(ready_o), .success_o(success_o), .cnt_err_o(cnt_err_o),
    .trans_err_o(trans_err_o), .token_err_o(token_err_o), .otp_err_o(otp_err_o),
    .state_err_o(state_err_o), .alert_o(alert_o), .prog_req_o(prog_req_o),
    .prog_state_o(prog_state_o), .prog_count_o(prog_count_o));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string tag = "R1";

  task automatic chk(input string rq, input string nm, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, nm, act, exp);
    end
  endtask

  // behavioural reference
  int m_state, m_count, m_pstate, m_pcount;
  bit m_ready, m_esc, m_req, m_succ, m_cfull, m_terr, m_tkerr, m_oerr, m_serr, m_alert;
  bit m_vlegal, m_vtok, can_go;

  function automatic bit f_legal(int cur, int tgt);
    return (tgt > cur) && (tgt <= 20) && !(cur == 18 && tgt == 19);
  endfunction

  function automatic bit f_tok(int cur, int tgt, logic [TW-1:0] tk);
    logic [TW-1:0] need;
    need = '0;
    if (tgt == 19) need = K_RMA;
    else if (cur >= 2 && cur <= 14 && cur % 2 == 0) need = K_UNL;
    return tk == need;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_state = 23; m_count = 0; m_pstate = 0; m_pcount = 0;
      m_ready = 0; m_esc = 0; m_req = 0; m_succ = 0; m_cfull = 0;
      m_terr = 0; m_tkerr = 0; m_oerr = 0; m_serr = 0; m_alert = 0;
    end else begin
      can_go = start && m_ready && !m_req && !m_esc && !esc && m_state < 20;
      if (!m_ready && init_valid) begin
        m_ready = 1;
        if (init_count > 16 || init_state > 20) begin
          m_serr = 1; m_alert = 1; m_state = 22;
        end else begin
          m_state = (init_count == 16) ? 20 : int'(init_state);
        end
        m_count = (init_count > 16) ? 31 : int'(init_count);
        m_cfull = (init_count == 16);
      end
      if (m_req && ack) begin
        m_req = 0;
        m_count = m_pcount;
        if (m_count == 16) m_cfull = 1;
        if (ack_err) begin
          m_oerr = 1; m_alert = 1; m_state = 22;
        end else begin
          m_succ = m_vlegal && m_vtok;
          m_terr = !m_vlegal;
          m_tkerr = m_vlegal && !m_vtok;
          m_state = (m_count == 16) ? 20 : 21;
        end
      end else if (m_req && esc) begin
        m_req = 0;
      end else if (can_go) begin
        m_req = 1;
        m_vlegal = f_legal(m_state, int'(target));
        m_vtok = f_tok(m_state, int'(target), token);
        m_pstate = (m_vlegal && m_vtok) ? int'(target) : m_state;
        m_pcount = m_count + 1;
      end
      if (esc) m_esc = 1;
      if (m_esc) m_state = 22;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(tag, "state", int'(state_o), m_state);
      chk(tag, "count", int'(count_o), m_count);
      chk(tag, "ready", int'(ready_o), int'(m_ready));
      chk(tag, "success", int'(success_o), int'(m_succ));
      chk(tag, "cnt_err", int'(cnt_err_o), int'(m_cfull));
      chk(tag, "trans_err", int'(trans_err_o), int'(m_terr));
      chk(tag, "token_err", int'(token_err_o), int'(m_tkerr));
      chk(tag, "otp_err", int'(otp_err_o), int'(m_oerr));
      chk(tag, "state_err", int'(state_err_o), int'(m_serr));
      chk(tag, "alert", int'(alert_o), int'(m_alert));
      chk(tag, "prog_req", int'(prog_req_o), int'(m_req));
      if (m_req) begin
        chk(tag, "prog_state", int'(prog_state_o), m_pstate);
        chk(tag, "prog_count", int'(prog_count_o), m_pcount);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic do_init(input int s, input int c);
    @(negedge clk); init_valid = 1; init_state = 5'(s); init_count = CW'(c);
    @(negedge clk); init_valid = 0;
  endtask

  task automatic do_start(input int t, input logic [TW-1:0] tk);
    @(negedge clk); start = 1; target = 5'(t); token = tk;
    @(negedge clk); start = 0; token = '0;
  endtask

  task automatic do_ack(input bit err, input int gap);
    repeat (gap) @(negedge clk);
    ack = 1; ack_err = err;
    @(negedge clk); ack = 0; ack_err = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values, sampled while reset is held
    chk("R1", "state", int'(state_o), 23);
    chk("R1", "count", int'(count_o), 0);
    chk("R1", "ready", int'(ready_o), 0);
    chk("R1", "alert", int'(alert_o), 0);
    chk("R1", "prog_req", int'(prog_req_o), 0);
    rst = 0;

    tag = "R12"; do_start(1, '0);
    chk("R12", "prog_req before ready", int'(prog_req_o), 0);
    tag = "R2"; do_init(0, 0);
    chk("R2", "ready", int'(ready_o), 1);
    do_init(5, 7);
    chk("R2", "second load ignored", int'(count_o), 0);
    tag = "R9"; do_start(1, '0);
    chk("R9", "prog_req", int'(prog_req_o), 1);
    chk("R9", "prog_state", int'(prog_state_o), 1);
    chk("R9", "prog_count", int'(prog_count_o), 1);
    tag = "R12"; do_start(3, '0);
    chk("R12", "busy start ignored", int'(prog_state_o), 1);
    tag = "R4"; do_ack(0, 2);
    chk("R4", "success", int'(success_o), 1);
    chk("R4", "state", int'(state_o), 21);
    chk("R4", "count", int'(count_o), 1);
    chk("R9", "req dropped", int'(prog_req_o), 0);
    tag = "R12"; do_start(2, '0);
    chk("R12", "start after attempt", int'(prog_req_o), 0);

    tag = "R5"; do_reset(); do_init(16, 3); do_start(0, '0);
    chk("R5", "prog_state keeps current", int'(prog_state_o), 16);
    do_ack(0, 1);
    chk("R5", "trans_err", int'(trans_err_o), 1);
    chk("R5", "count", int'(count_o), 4);

    tag = "R6"; do_reset(); do_init(18, 2); do_start(19, K_RMA);
    chk("R6", "prog_state", int'(prog_state_o), 18);
    do_ack(0, 0);
    chk("R6", "trans_err", int'(trans_err_o), 1);

    tag = "R7"; do_reset(); do_init(2, 1); do_start(3, K_RMA); do_ack(0, 0);
    chk("R7", "token_err wrong unlock", int'(token_err_o), 1);
    chk("R7", "trans_err", int'(trans_err_o), 0);
    do_reset(); do_init(2, 1); do_start(3, K_UNL);
    chk("R7", "prog_state", int'(prog_state_o), 3);
    do_ack(0, 0);
    chk("R7", "success unlock", int'(success_o), 1);
    do_reset(); do_init(17, 4); do_start(19, K_RMA); do_ack(0, 1);
    chk("R7", "success rma", int'(success_o), 1);
    chk("R7", "count", int'(count_o), 5);

    tag = "R8"; do_reset(); do_init(16, 0); do_start(17, 128'h1); do_ack(0, 0);
    chk("R8", "token_err nonzero", int'(token_err_o), 1);

    tag = "R10"; do_reset(); do_init(0, 0); do_start(1, '0); do_ack(1, 0);
    chk("R10", "otp_err", int'(otp_err_o), 1);
    chk("R10", "state", int'(state_o), 22);
    chk("R10", "count", int'(count_o), 1);
    chk("R10", "alert", int'(alert_o), 1);
    tag = "R14"; do_start(5, '0); repeat (5) @(negedge clk);
    chk("R14", "otp_err held", int'(otp_err_o), 1);
    chk("R14", "alert held", int'(alert_o), 1);

    tag = "R11"; do_reset(); do_init(16, 15); do_start(17, '0); do_ack(0, 0);
    chk("R11", "count", int'(count_o), 16);
    chk("R11", "state", int'(state_o), 20);
    chk("R11", "cnt_err", int'(cnt_err_o), 1);
    do_reset(); do_init(5, 16);
    chk("R11", "state on full load", int'(state_o), 20);
    do_start(6, '0);
    chk("R11", "start refused", int'(prog_req_o), 0);

    tag = "R3"; do_reset(); do_init(3, 20);
    chk("R3", "count corrupt", int'(count_o), 31);
    chk("R3", "state_err", int'(state_err_o), 1);
    chk("R3", "state", int'(state_o), 22);
    do_reset(); do_init(25, 2);
    chk("R3", "state_err bad code", int'(state_err_o), 1);
    chk("R3", "alert", int'(alert_o), 1);

    tag = "R13"; do_reset(); do_init(0, 0); do_start(1, '0);
    esc = 1; @(negedge clk); esc = 0;
    chk("R13", "state", int'(state_o), 22);
    chk("R13", "withdrawn", int'(prog_req_o), 0);
    do_ack(0, 2);
    chk("R13", "late ack ignored", int'(count_o), 0);
    do_reset(); do_init(0, 0); do_start(1, '0);
    esc = 1; ack = 1; @(negedge clk); esc = 0; ack = 0;
    chk("R13", "collision count", int'(count_o), 1);
    chk("R13", "collision success", int'(success_o), 1);
    chk("R13", "collision state", int'(state_o), 22);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule